// File: doc/BRIEF.md
# Per-CPU Event Timer Bank

This block holds a small set of identical down-counting event timers, one per CPU, behind a simple register write/read port. Each timer is programmed by a single control word. That word carries a run flag, a mode flag that chooses between single-shot and repeating operation, and a reload count. The timer then counts on the block clock, which is the fixed oscillator clock. When the count runs out, the timer raises a level interrupt. The interrupt stays high until software clears it through a separate per-timer register.

Timers sit at a fixed address stride from a base offset, so each CPU can address its own timer. A count value N yields an interval of N+1 clocks. In repeating mode the timer reloads itself at every expiry. In single-shot mode it drops its run flag after the first expiry. A second register per timer reads back the live count together with the pending interrupt.

Top module: `evt_timer_bank`

## Requirements
- R1: After reset every timer is stopped with zero reload and count, all `irq` bits are 0, and every register reads 0.
- R2: Timer i has its control register at 0x90 + 8*i and its clear/status register at 0x94 + 8*i. A write to any other address changes nothing, and a read of any other address returns 0.
- R3: A control write loads three fields and restarts the count from the new value in the same clock: bit 31 is the run flag, bit 30 is the mode (1 = repeating, 0 = single-shot), and bits 28:0 are the reload count.
- R4: A timer written with count N and run flag 1 raises its `irq` on the (N+1)-th rising clock edge after the write edge, so N = 0 gives a one-clock interval.
- R5: In single-shot mode the run flag clears at expiry and the count stays at 0; the control register then reads with bit 31 = 0.
- R6: In repeating mode the counter is reloaded at expiry and keeps running, so expiries occur every N+1 clocks.
- R7: Writing all zeros to a control register stops that timer, and an interrupt already pending stays set.
- R8: `irq[i]` stays high from expiry until a write to the timer's clear/status register with bit 30 = 1; a write there with bit 30 = 0 has no effect.
- R9: A clear that lands on the same edge as an expiry leaves `irq` asserted.
- R10: A control write that lands on the same edge as an expiry takes precedence: that expiry raises no interrupt, and the new count is loaded.
- R11: A control register reads back {run, mode, 0, reload[28:0]} in bits 31, 30, 29 and 28:0. A clear/status register reads back the pending interrupt in bit 30 and the live count in bits 28:0, with all other bits 0.
- R12: A write to one timer leaves the registers and interrupt of every other timer unchanged.
- R13: The count field is 29 bits wide, so 0x1FFFFFFF is accepted. Bit 29 of a control write is ignored and reads back as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock; each timer counts once per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W | Byte address of the register being written or read |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| irq | output | NUM_TIMERS | Level interrupt per timer |

## Verification
The bench drives each timer in four ways, and each one separates a different class of fault:
- A single-shot timer with a small count and with count zero exposes off-by-one errors in the N+1 interval.
- A repeating timer, read every cycle, shows whether reload happens at zero or one clock late.
- Writes placed exactly on an expiry edge, once as a clear and once as a reload, tell apart the two priority orders in R9 and R10.
- Writes to unmapped, misaligned and neighbouring addresses, plus a maximum-count load, show decode leaks between timers and the masking of bit 29.

A behavioural reference model is compared against `irq` and the read data on every clock.

// File: rtl/evt_tmr_pkg.sv
package evt_tmr_pkg;
   localparam int RUN_BIT  = 31;
   localparam int MODE_BIT = 30;
   localparam int CLR_BIT  = 30;
   localparam int PEND_BIT = 30;
   localparam int STAT_OFS = 4;

   typedef enum logic {
      MODE_ONESHOT  = 1'b0,
      MODE_PERIODIC = 1'b1
   } tmr_mode_e;
endpackage

// File: rtl/evt_tmr_addr_dec.sv
module evt_tmr_addr_dec
   import evt_tmr_pkg::*;
#(
   parameter int NUM    = 4,
   parameter int ADDR_W = 8,
   parameter int BASE   = 'h90,
   parameter int STRIDE = 8
)(
   input  logic [ADDR_W-1:0] addr,
   output logic [NUM-1:0]    ctrl_hit,
   output logic [NUM-1:0]    stat_hit
);
   for (genvar g = 0; g < NUM; g++) begin : g_slot
      localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(BASE + STRIDE * g);
      localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(BASE + STRIDE * g + STAT_OFS);
      assign ctrl_hit[g] = (addr == A_CTRL);
      assign stat_hit[g] = (addr == A_STAT);
   end
endmodule

// File: rtl/evt_tmr_channel.sv
module evt_tmr_channel
   import evt_tmr_pkg::*;
#(
   parameter int CNT_W = 29
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_we,
   input  logic             ld_run,
   input  tmr_mode_e        ld_mode,
   input  logic [CNT_W-1:0] ld_cnt,
   input  logic             clr_we,
   input  logic             clr_req,
   output logic             run,
   output tmr_mode_e        mode,
   output logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] count,
   output logic             pend
);
   logic at_zero;
   logic fire;

   assign at_zero = (count == '0);
   assign fire    = run && at_zero && !ld_we;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run    <= 1'b0;
         mode   <= MODE_ONESHOT;
         reload <= '0;
         count  <= '0;
      end else if (ld_we) begin
         run    <= ld_run;
         mode   <= ld_mode;
         reload <= ld_cnt;
         count  <= ld_cnt;
      end else if (run) begin
         if (at_zero) begin
            if (mode == MODE_PERIODIC) count <= reload;
            else                       run   <= 1'b0;
         end else begin
            count <= count - 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 pend <= 1'b0;
      else if (fire)              pend <= 1'b1;
      else if (clr_we && clr_req) pend <= 1'b0;
   end

   p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ld_we |=> (count == $past(ld_cnt)) && (run == $past(ld_run)));

   p_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend) |-> ($past(run) && ($past(count) == '0)));

   p_oneshot_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && at_zero && !ld_we && mode == MODE_ONESHOT) |=> (!run && count == '0));

   p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && at_zero && !ld_we && mode == MODE_PERIODIC) |=> (run && count == $past(reload)));

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !(clr_we && clr_req)) |=> pend);

   p_tie_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (run && at_zero && !ld_we && clr_we && clr_req) |=> pend);

   p_wr_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_we && !pend) |=> !pend);
endmodule

// File: rtl/evt_tmr_rdmux.sv
module evt_tmr_rdmux
   import evt_tmr_pkg::*;
#(
   parameter int NUM    = 4,
   parameter int CNT_W  = 29,
   parameter int DATA_W = 32
)(
   input  logic [NUM-1:0]            ctrl_hit,
   input  logic [NUM-1:0]            stat_hit,
   input  logic [NUM-1:0]            run_v,
   input  logic [NUM-1:0]            per_v,
   input  logic [NUM-1:0]            pend_v,
   input  logic [NUM-1:0][CNT_W-1:0] reload_v,
   input  logic [NUM-1:0][CNT_W-1:0] count_v,
   output logic [DATA_W-1:0]         rdata
);
   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM; i++) begin
         if (ctrl_hit[i]) begin
            rdata[RUN_BIT]     = run_v[i];
            rdata[MODE_BIT]    = per_v[i];
            rdata[CNT_W-1:0]   = reload_v[i];
         end
         if (stat_hit[i]) begin
            rdata[PEND_BIT]    = pend_v[i];
            rdata[CNT_W-1:0]   = count_v[i];
         end
      end
   end
endmodule

// File: rtl/evt_timer_bank.sv
module evt_timer_bank
   import evt_tmr_pkg::*;
#(
   parameter int NUM_TIMERS = 4,
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 32,
   parameter int CNT_W      = 29,
   parameter int BASE_OFF   = 'h90,
   parameter int STRIDE     = 8
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_we,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   output logic [NUM_TIMERS-1:0] irq
);
   localparam int TOP_ADDR = BASE_OFF + STRIDE * NUM_TIMERS;

   if (DATA_W != 32) begin : g_chk_dw
      $error("evt_timer_bank: DATA_W must be 32");
   end
   if (CNT_W < 1 || CNT_W > 29) begin : g_chk_cw
      $error("evt_timer_bank: CNT_W must lie in 1..29");
   end
   if (STRIDE < 8 || (STRIDE % 4) != 0) begin : g_chk_st
      $error("evt_timer_bank: STRIDE must be a multiple of 4 and at least 8");
   end
   if (TOP_ADDR > (1 << ADDR_W)) begin : g_chk_aw
      $error("evt_timer_bank: register window exceeds ADDR_W");
   end

   logic [NUM_TIMERS-1:0]            ctrl_hit, stat_hit;
   logic [NUM_TIMERS-1:0]            run_v, per_v, pend_v;
   logic [NUM_TIMERS-1:0][CNT_W-1:0] reload_v, count_v;
   logic                             unused_wbits;

   assign unused_wbits = ^bus_wdata[29:CNT_W];

   evt_tmr_addr_dec #(
      .NUM(NUM_TIMERS), .ADDR_W(ADDR_W), .BASE(BASE_OFF), .STRIDE(STRIDE)
   ) u_dec (
      .addr(bus_addr), .ctrl_hit(ctrl_hit), .stat_hit(stat_hit)
   );

   for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tmr
      tmr_mode_e mode_q;

      evt_tmr_channel #(.CNT_W(CNT_W)) u_ch (
         .clk     (clk),
         .rst_n   (rst_n),
         .ld_we   (bus_we && ctrl_hit[g]),
         .ld_run  (bus_wdata[RUN_BIT]),
         .ld_mode (tmr_mode_e'(bus_wdata[MODE_BIT])),
         .ld_cnt  (bus_wdata[CNT_W-1:0]),
         .clr_we  (bus_we && stat_hit[g]),
         .clr_req (bus_wdata[CLR_BIT]),
         .run     (run_v[g]),
         .mode    (mode_q),
         .reload  (reload_v[g]),
         .count   (count_v[g]),
         .pend    (pend_v[g])
      );

      assign per_v[g] = (mode_q == MODE_PERIODIC);
   end

   evt_tmr_rdmux #(
      .NUM(NUM_TIMERS), .CNT_W(CNT_W), .DATA_W(DATA_W)
   ) u_rd (
      .ctrl_hit (ctrl_hit),
      .stat_hit (stat_hit),
      .run_v    (run_v),
      .per_v    (per_v),
      .pend_v   (pend_v),
      .reload_v (reload_v),
      .count_v  (count_v),
      .rdata    (bus_rdata)
   );

   assign irq = pend_v;

   p_unmapped_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(|{ctrl_hit, stat_hit}) |-> (bus_rdata == '0));

   p_bit29_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata[29] == 1'b0));
endmodule

// File: tb/evt_timer_bank_tb.sv
module evt_timer_bank_tb;
   localparam int NT   = 4;
   localparam int BASE = 'h90;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [NT-1:0] irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   evt_timer_bank u_dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   // behavioural reference state
   bit          m_en  [NT];
   bit          m_per [NT];
   bit          m_irq [NT];
   int unsigned m_rel [NT];
   int unsigned m_cnt [NT];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] m_read(input logic [7:0] a);
      for (int i = 0; i < NT; i++) begin
         if (a == 8'(BASE + 8 * i))
            return {m_en[i], m_per[i], 1'b0, m_rel[i][28:0]};
         if (a == 8'(BASE + 8 * i + 4))
            return {1'b0, m_irq[i], 1'b0, m_cnt[i][28:0]};
      end
      return 32'h0;
   endfunction

   function automatic logic [NT-1:0] m_irqv();
      logic [NT-1:0] v;
      for (int i = 0; i < NT; i++) v[i] = m_irq[i];
      return v;
   endfunction

   always @(posedge clk) begin
      for (int i = 0; i < NT; i++) begin
         bit cw, sw, ex;
         if (!rst_n) begin
            m_en[i] = 0; m_per[i] = 0; m_irq[i] = 0; m_rel[i] = 0; m_cnt[i] = 0;
         end else begin
            cw = bus_we && (bus_addr == 8'(BASE + 8 * i));
            sw = bus_we && (bus_addr == 8'(BASE + 8 * i + 4));
            ex = m_en[i] && (m_cnt[i] == 0) && !cw;
            if (ex) m_irq[i] = 1;
            else if (sw && bus_wdata[30]) m_irq[i] = 0;
            if (cw) begin
               m_en[i]  = bus_wdata[31];
               m_per[i] = bus_wdata[30];
               m_rel[i] = {3'b000, bus_wdata[28:0]};
               m_cnt[i] = m_rel[i];
            end else if (m_en[i]) begin
               if (m_cnt[i] == 0) begin
                  if (m_per[i]) m_cnt[i] = m_rel[i];
                  else          m_en[i]  = 0;
               end else begin
                  m_cnt[i] = m_cnt[i] - 1;
               end
            end
         end
      end
      #1;
      chk("R4 model irq", 32'(irq), 32'(m_irqv()));
      chk("R11 model rdata", bus_rdata, m_read(bus_addr));
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      chk("R1 irq", 32'(irq), 32'h0);
      rd(8'h90, v); chk("R1 ctrl0", v, 32'h0);
      rd(8'hAC, v); chk("R1 stat3", v, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: unmapped and misaligned writes/reads
      rd(8'h00, v); chk("R2 unmapped read", v, 32'h0);
      rd(8'hB0, v); chk("R2 past-end read", v, 32'h0);
      wr(8'h00, 32'hC000_0005);
      wr(8'h92, 32'hC000_0005);
      rd(8'h90, v); chk("R2 ignored write", v, 32'h0);

      // R13: max count, bit 29 masked
      wr(8'h90, 32'h7FFF_FFFF);
      rd(8'h90, v); chk("R13 readback", v, 32'h5FFF_FFFF);
      wr(8'h90, 32'h9FFF_FFFF);
      rd(8'h94, v); chk("R3 load max", v, 32'h1FFF_FFFF);
      @(negedge clk);
      rd(8'h94, v); chk("R13 decrement", v, 32'h1FFF_FFFE);
      wr(8'h90, 32'h0);
      rd(8'h90, v); chk("R7 stop ctrl", v, 32'h0);
      @(negedge clk);
      rd(8'h94, v); chk("R7 stop stat", v, 32'h0);

      // R4 / R5: single-shot N=3
      wr(8'h90, 32'h8000_0003);
      repeat (3) @(negedge clk);
      chk("R4 before expiry", 32'(irq[0]), 32'h0);
      @(negedge clk);
      chk("R4 at expiry", 32'(irq[0]), 32'h1);
      rd(8'h90, v); chk("R5 run cleared", v, 32'h0000_0003);
      rd(8'h94, v); chk("R11 status pend", v, 32'h4000_0000);
      repeat (5) @(negedge clk);
      chk("R8 level held", 32'(irq[0]), 32'h1);
      wr(8'h94, 32'h0);
      chk("R8 clear bit0 ignored", 32'(irq[0]), 32'h1);
      wr(8'h94, 32'h4000_0000);
      chk("R8 cleared", 32'(irq[0]), 32'h0);

      // R4: N=0 gives a one-clock interval
      wr(8'h90, 32'h8000_0000);
      chk("R4 N0 not yet", 32'(irq[0]), 32'h0);
      @(negedge clk);
      chk("R4 N0 expiry", 32'(irq[0]), 32'h1);
      wr(8'h94, 32'h4000_0000);

      // R6: repeating N=2 on timer 1
      wr(8'h98, 32'hC000_0002);
      rd(8'h9C, v); chk("R6 cnt2", v, 32'h0000_0002);
      @(negedge clk); rd(8'h9C, v); chk("R6 cnt1", v, 32'h0000_0001);
      @(negedge clk); rd(8'h9C, v); chk("R6 cnt0", v, 32'h0000_0000);
      @(negedge clk); rd(8'h9C, v); chk("R6 reload", v, 32'h4000_0002);
      wr(8'h9C, 32'h4000_0000);
      chk("R8 clear periodic", 32'(irq[1]), 32'h0);
      rd(8'h9C, v); chk("R6 running", v, 32'h0000_0001);
      @(negedge clk);
      chk("R6 gap", 32'(irq[1]), 32'h0);
      @(negedge clk);
      chk("R6 second expiry", 32'(irq[1]), 32'h1);

      // R7: stop keeps pending interrupt
      wr(8'h98, 32'h0);
      rd(8'h98, v); chk("R7 ctrl zero", v, 32'h0);
      repeat (4) @(negedge clk);
      chk("R7 irq kept", 32'(irq[1]), 32'h1);
      rd(8'h9C, v); chk("R7 status", v, 32'h4000_0000);
      wr(8'h9C, 32'h4000_0000);

      // R9: clear on the expiry edge
      wr(8'hA0, 32'h8000_0005);
      repeat (5) @(negedge clk);
      wr(8'hA4, 32'h4000_0000);
      chk("R9 tie keeps irq", 32'(irq[2]), 32'h1);
      wr(8'hA4, 32'h4000_0000);
      chk("R9 later clear", 32'(irq[2]), 32'h0);

      // R10: control write on the expiry edge
      wr(8'hA8, 32'h8000_0002);
      repeat (2) @(negedge clk);
      wr(8'hA8, 32'hC000_000A);
      chk("R10 no irq", 32'(irq[3]), 32'h0);
      rd(8'hAC, v); chk("R10 new count", v, 32'h0000_000A);

      // R12: other timers untouched
      rd(8'h90, v); chk("R12 timer0", v, 32'h0);
      rd(8'h98, v); chk("R12 timer1", v, 32'h0);
      chk("R12 irq others", 32'(irq[2:0]), 32'h0);

      repeat (30) @(negedge clk);
      wr(8'hA8, 32'h0);
      wr(8'hAC, 32'h4000_0000);
      @(negedge clk);
      chk("R8 all clear", 32'(irq), 32'h0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
   end
endmodule